// File: doc/BRIEF.md
# Calibrated Real-Time Clock

This block keeps wall-clock time of day from a slow oscillator that reaches it as a one-cycle clock-enable pulse on `osc_tick`. A sub-second divider counts those pulses up to a programmable rate and produces a second event. Before the divider, a trim stage lengthens or shortens one second in every window of a programmable number of seconds. The trim amount is signed and counted in oscillator pulses. The trim compensates for an oscillator that runs off its nominal frequency, so the long-run average second stays exact.

Seconds, minutes and hours counters advance on that event and carry into one another. Software reads and writes them over a simple register bus. Five event sources each have a sticky flag and an enable bit: half second, second, minute, hour and day. Any enabled flag that is set drives `irq` high. Register reads are combinational from `bus_addr`. Writes take effect at the clock edge where `bus_sel` and `bus_wr` are high.

Register addresses: 0 seconds, 1 minutes, 2 hours, 3 rate (oscillator pulses per nominal second), 4 trim (bits [7:0] signed trim, bits [15:8] window length in seconds), 5 event flags, 6 event enables, 7 unused. Flag and enable bits: bit0 half second, bit1 second, bit2 minute, bit3 hour, bit4 day.

Top module: `rtc_top`

## Requirements
- R1: After synchronous reset, time reads 00:00:00, rate reads 32768, the trim register reads 0, flags and enables read 0 and `irq` is low.
- R2: With trim inactive, the second event occurs on the rate-th oscillator pulse after the divider was last restarted or wrapped. The second event increments the seconds field and sets flag bit1.
- R3: Seconds and minutes wrap from 59 to 0 and carry into the next field, setting flag bit2 and flag bit3 respectively. Hours wrap from 23 to 0 and set flag bit4 (day).
- R4: Flag bit0 (half second) is set on the pulse where the divider count reaches floor(length/2), and again on the pulse that completes the second.
- R5: When the window field is nonzero, one second in every window lasts rate plus the signed trim, and all other seconds last rate. The trimmed second is the window-th second counted since the window counter last cleared. A length below 2 is raised to 2. A window of 0 disables trimming.
- R6: A write to address 0, 1 or 2 loads the low 8 data bits into that field. A value above 59 (seconds, minutes) or 23 (hours) loads 0. The write restarts the divider, and an oscillator pulse in the same cycle is not counted.
- R7: Event flags are sticky. Writing 1 to a bit at address 5 clears it, writing 0 leaves it, and an event in the same cycle as a clear leaves the bit set.
- R8: `irq` is high exactly when some flag bit and the matching enable bit at address 6 are both 1.
- R9: Address 3 reads back the rate, address 4 reads back the window in [15:8] and the trim in [7:0], and address 7 reads 0.
- R10: A pulse sampled at a clock edge updates time and flags at that same edge, and the result is visible on `bus_rdata` and `irq` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| irq | output | 1 | OR of enabled event flags |

## Verification
Every result is registered at the edge that samples the pulse or write, and reads are combinational. A tick or write driven for one cycle from a falling edge is therefore fully reflected at the next falling edge. The bench samples `bus_rdata` and `irq` there, after setting the address one nanosecond earlier. A bench model is stepped once per driven pulse or write and predicts the time fields, the flags and `irq`. Directed runs count pulses between second increments to pin down the trimmed and clamped second lengths, the divider restart and the half-second instant.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int SEC_W = 6;
    localparam int MIN_W = 6;
    localparam int HR_W  = 5;
    localparam int EV_N  = 5;

    localparam logic [7:0] SEC_MAX = 8'd59;
    localparam logic [7:0] MIN_MAX = 8'd59;
    localparam logic [7:0] HR_MAX  = 8'd23;

    typedef struct packed {
        logic [HR_W-1:0]  hr;
        logic [MIN_W-1:0] mn;
        logic [SEC_W-1:0] sc;
    } clock_t;

    // bit0 = half second ... bit4 = day
    typedef struct packed {
        logic day;
        logic hour;
        logic minute;
        logic second;
        logic half;
    } events_t;

    typedef enum logic [2:0] {
        RA_SEC  = 3'd0,
        RA_MIN  = 3'd1,
        RA_HR   = 3'd2,
        RA_RATE = 3'd3,
        RA_TRIM = 3'd4,
        RA_FLAG = 3'd5,
        RA_MASK = 3'd6,
        RA_NONE = 3'd7
    } reg_addr_e;

    function automatic logic [7:0] fit_field(input logic [7:0] val, input logic [7:0] top);
        return (val > top) ? 8'd0 : val;
    endfunction

endpackage

// File: rtl/rtc_div.sv
module rtc_div #(
    parameter int CNT_W = 16,
    parameter int CAL_W = 8,
    parameter int WIN_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  logic                    restart,
    input  logic [CNT_W-1:0]        rate,
    input  logic signed [CAL_W-1:0] trim,
    input  logic [WIN_W-1:0]        window,
    output logic                    half_ev,
    output logic                    sec_ev,
    output logic [CNT_W:0]          sub_cnt
);

    localparam int LEN_W = CNT_W + 2;

    logic [WIN_W-1:0]        wcnt;
    logic                    apply;
    logic signed [LEN_W-1:0] len_raw;
    logic [CNT_W:0]          len;
    logic [CNT_W:0]          mid;
    logic [CNT_W:0]          sub_inc;

    always_comb begin
        apply   = (window != '0) && (wcnt >= (window - 1'b1));
        len_raw = $signed({2'b00, rate});
        if (apply) begin
            len_raw = len_raw + LEN_W'(trim);
        end
        if (len_raw < $signed(LEN_W'(2))) begin
            len = (CNT_W + 1)'(2);
        end else begin
            len = len_raw[CNT_W:0];
        end
        mid     = len >> 1;
        sub_inc = sub_cnt + 1'b1;
        sec_ev  = tick && !restart && (sub_inc >= len);
        half_ev = tick && !restart && (sec_ev || (sub_inc == mid));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_cnt <= '0;
            wcnt    <= '0;
        end else begin
            if (restart) begin
                sub_cnt <= '0;
            end else if (tick) begin
                sub_cnt <= sec_ev ? '0 : sub_inc;
            end
            if (sec_ev) begin
                wcnt <= ((window == '0) || apply) ? '0 : wcnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rtc_time.sv
module rtc_time
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_ev,
    input  logic [2:0] load,
    input  logic [7:0] wval,
    output clock_t     now,
    output logic       min_ev,
    output logic       hr_ev,
    output logic       day_ev
);

    logic [7:0] sc_in;
    logic [7:0] mn_in;
    logic [7:0] hr_in;

    always_comb begin
        min_ev = sec_ev && (8'(now.sc) == SEC_MAX);
        hr_ev  = min_ev && (8'(now.mn) == MIN_MAX);
        day_ev = hr_ev  && (8'(now.hr) == HR_MAX);
        sc_in  = fit_field(wval, SEC_MAX);
        mn_in  = fit_field(wval, MIN_MAX);
        hr_in  = fit_field(wval, HR_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            now <= '0;
        end else begin
            if (load[0]) begin
                now.sc <= sc_in[SEC_W-1:0];
            end else if (sec_ev) begin
                now.sc <= min_ev ? '0 : now.sc + 1'b1;
            end
            if (load[1]) begin
                now.mn <= mn_in[MIN_W-1:0];
            end else if (min_ev) begin
                now.mn <= hr_ev ? '0 : now.mn + 1'b1;
            end
            if (load[2]) begin
                now.hr <= hr_in[HR_W-1:0];
            end else if (hr_ev) begin
                now.hr <= day_ev ? '0 : now.hr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rtc_irq.sv
module rtc_irq #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] flags,
    output logic         irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr) | set;
        end
    end

    assign irq = |(flags & mask);

endmodule

// File: rtl/rtc_top.sv
module rtc_top
    import rtc_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int CAL_W   = 8,
    parameter int WIN_W   = 8,
    parameter int DATA_W  = 16,
    parameter int DEF_TPS = 32768
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    reg_addr_e               ra;
    logic                    wr;
    logic [2:0]              load;
    logic                    restart;
    logic [CNT_W-1:0]        rate;
    logic signed [CAL_W-1:0] trim;
    logic [WIN_W-1:0]        window;
    logic [EV_N-1:0]         mask;
    logic [EV_N-1:0]         flags;
    logic [EV_N-1:0]         clr;
    logic [CNT_W:0]          sub_cnt;
    clock_t                  now;
    events_t                 ev;

    assign ra = reg_addr_e'(bus_addr);
    assign wr = bus_sel && bus_wr;

    always_comb begin
        load    = '0;
        clr     = '0;
        if (wr) begin
            case (ra)
                RA_SEC:  load[0] = 1'b1;
                RA_MIN:  load[1] = 1'b1;
                RA_HR:   load[2] = 1'b1;
                RA_FLAG: clr     = bus_wdata[EV_N-1:0];
                default: ;
            endcase
        end
        restart = |load;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rate   <= CNT_W'(DEF_TPS);
            trim   <= '0;
            window <= '0;
            mask   <= '0;
        end else if (wr) begin
            case (ra)
                RA_RATE: rate <= bus_wdata[CNT_W-1:0];
                RA_TRIM: begin
                    trim   <= bus_wdata[CAL_W-1:0];
                    window <= bus_wdata[CAL_W +: WIN_W];
                end
                RA_MASK: mask <= bus_wdata[EV_N-1:0];
                default: ;
            endcase
        end
    end

    rtc_div #(
        .CNT_W(CNT_W),
        .CAL_W(CAL_W),
        .WIN_W(WIN_W)
    ) div_i (
        .clk     (clk),
        .rst     (rst),
        .tick    (osc_tick),
        .restart (restart),
        .rate    (rate),
        .trim    (trim),
        .window  (window),
        .half_ev (ev.half),
        .sec_ev  (ev.second),
        .sub_cnt (sub_cnt)
    );

    rtc_time time_i (
        .clk    (clk),
        .rst    (rst),
        .sec_ev (ev.second),
        .load   (load),
        .wval   (bus_wdata[7:0]),
        .now    (now),
        .min_ev (ev.minute),
        .hr_ev  (ev.hour),
        .day_ev (ev.day)
    );

    rtc_irq #(
        .N(EV_N)
    ) irq_i (
        .clk   (clk),
        .rst   (rst),
        .set   (ev),
        .clr   (clr),
        .mask  (mask),
        .flags (flags),
        .irq   (irq)
    );

    always_comb begin
        case (ra)
            RA_SEC:  bus_rdata = DATA_W'(now.sc);
            RA_MIN:  bus_rdata = DATA_W'(now.mn);
            RA_HR:   bus_rdata = DATA_W'(now.hr);
            RA_RATE: bus_rdata = DATA_W'(rate);
            RA_TRIM: bus_rdata = DATA_W'({window, trim});
            RA_FLAG: bus_rdata = DATA_W'(flags);
            RA_MASK: bus_rdata = DATA_W'(mask);
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
    import rtc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            bus_sel,
    input logic            bus_wr,
    input logic [2:0]      bus_addr,
    input clock_t          now,
    input logic [CNT_W:0]  sub_cnt,
    input logic [EV_N-1:0] flags,
    input logic            irq
);

    logic twr;
    logic fclr;
    assign twr  = bus_sel && bus_wr && (bus_addr <= 3'd2);
    assign fclr = bus_sel && bus_wr && (bus_addr == 3'd5);

    AST_SEC_RANGE: assert property (@(posedge clk) disable iff (rst)
        8'(now.sc) <= SEC_MAX && 8'(now.mn) <= MIN_MAX); // R3

    AST_HR_RANGE: assert property (@(posedge clk) disable iff (rst)
        8'(now.hr) <= HR_MAX); // R3

    AST_MIN_CARRY: assert property (@(posedge clk) disable iff (rst)
        ($past(now.sc) == SEC_W'(59) && now.sc == '0 && !$past(twr))
        |-> (now.mn != $past(now.mn))); // R3

    AST_DAY_FLAG: assert property (@(posedge clk) disable iff (rst)
        ($past(now.hr) == HR_W'(23) && now.hr == '0 && !$past(twr))
        |-> flags[4]); // R3

    AST_WR_RESTARTS_DIV: assert property (@(posedge clk) disable iff (rst)
        twr |=> (sub_cnt == '0)); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        !fclr |=> ((flags & $past(flags)) == $past(flags))); // R7

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (flags == '0) |-> !irq); // R8

endmodule

bind rtc_top rtc_checker #(
    .CNT_W(CNT_W)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .now      (now),
    .sub_cnt  (sub_cnt),
    .flags    (flags),
    .irq      (irq)
);

// File: tb/rtc_top_tb_top.sv
`timescale 1ns/1ps
module rtc_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        osc_tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    wire  [15:0] bus_rdata;
    wire         irq;

    int checks = 0;
    int fails  = 0;

    int m_sc, m_mn, m_hr, m_sub, m_wcnt, m_rate, m_trim, m_win, m_flags, m_mask;

    always #5 clk = ~clk;

    rtc_top dut_i (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit m_apply();
        return (m_win != 0) && (m_wcnt >= m_win - 1);
    endfunction

    function automatic int m_len();
        int len;
        len = m_rate + (m_apply() ? m_trim : 0);
        if (len < 2) len = 2;
        return len;
    endfunction

    task automatic m_tick();
        int  len;
        bit  ap;
        len = m_len();
        ap  = m_apply();
        if (m_sub + 1 >= len) begin
            m_sub   = 0;
            m_flags = m_flags | 3;
            m_wcnt  = (m_win == 0 || ap) ? 0 : (m_wcnt + 1) % 256;
            if (m_sc == 59) begin
                m_sc = 0;
                m_flags = m_flags | 4;
                if (m_mn == 59) begin
                    m_mn = 0;
                    m_flags = m_flags | 8;
                    if (m_hr == 23) begin
                        m_hr = 0;
                        m_flags = m_flags | 16;
                    end else m_hr++;
                end else m_mn++;
            end else m_sc++;
        end else begin
            m_sub++;
            if (m_sub == len / 2) m_flags = m_flags | 1;
        end
    endtask

    task automatic do_tick();
        @(negedge clk);
        osc_tick = 1'b1;
        @(negedge clk);
        osc_tick = 1'b0;
        m_tick();
    endtask

    task automatic do_write(input int addr, input int data, input bit with_tick = 1'b0);
        logic [15:0] d;
        d = data[15:0];
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = addr[2:0]; bus_wdata = d;
        osc_tick = with_tick;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; osc_tick = 1'b0;
        case (addr)
            0: begin m_sc = (d[7:0] > 59) ? 0 : int'(d[7:0]); m_sub = 0; end
            1: begin m_mn = (d[7:0] > 59) ? 0 : int'(d[7:0]); m_sub = 0; end
            2: begin m_hr = (d[7:0] > 23) ? 0 : int'(d[7:0]); m_sub = 0; end
            3: m_rate = int'(d);
            4: begin m_trim = int'($signed(d[7:0])); m_win = int'(d[15:8]); end
            5: m_flags = m_flags & ~int'(d[4:0]);
            6: m_mask = int'(d[4:0]);
            default: ;
        endcase
        if (with_tick && addr > 2) m_tick();
    endtask

    task automatic do_read(input int addr, output int v);
        @(negedge clk);
        bus_addr = addr[2:0];
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic check_all(input string req);
        int v;
        do_read(0, v); chk({req, " sec"}, v, m_sc);
        do_read(1, v); chk({req, " min"}, v, m_mn);
        do_read(2, v); chk({req, " hr"}, v, m_hr);
        do_read(5, v); chk({req, " flags R7"}, v, m_flags);
        chk({req, " irq R8"}, int'(irq), int'((m_flags & m_mask) != 0));
    endtask

    task automatic ticks_to_second(output int n);
        int s0, v;
        do_read(0, s0);
        n = 0;
        for (int i = 0; i < 100; i++) begin
            do_tick();
            n++;
            do_read(0, v);
            if (v != s0) break;
        end
    endtask

    initial begin
        #1_500_000;
        checks++;
        fails++;
        $display("FAIL R10 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int v, n;
        void'($urandom(32'd2024));
        m_sc = 0; m_mn = 0; m_hr = 0; m_sub = 0; m_wcnt = 0;
        m_rate = 32768; m_trim = 0; m_win = 0; m_flags = 0; m_mask = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        do_read(0, v); chk("R1 sec", v, 0);
        do_read(1, v); chk("R1 min", v, 0);
        do_read(2, v); chk("R1 hr", v, 0);
        do_read(3, v); chk("R1 rate", v, 32768);
        do_read(4, v); chk("R1 trim", v, 0);
        do_read(5, v); chk("R1 flags", v, 0);
        do_read(6, v); chk("R1 mask", v, 0);
        chk("R1 irq", int'(irq), 0);

        // R9 readback
        do_write(3, 4);
        do_read(3, v); chk("R9 rate", v, 4);
        do_write(4, 16'h0302);
        do_read(4, v); chk("R9 trim", v, 16'h0302);
        do_write(4, 0);
        do_read(7, v); chk("R9 unused", v, 0);

        // R2 / R4 / R10 : rate 4, half at pulse 2, second at pulse 4
        do_tick();
        do_read(5, v); chk("R4 no half yet", v, 0);
        do_tick();
        do_read(5, v); chk("R4 half at midpoint", v, 1);
        do_write(5, 1);
        do_tick();
        do_read(0, v); chk("R2 sec not yet", v, 0);
        do_tick();
        do_read(0, v); chk("R10 sec after 4th pulse", v, 1);
        do_read(5, v); chk("R2 R4 flags at end", v, 3);

        // R7 write-one-to-clear
        do_write(5, 2);
        do_read(5, v); chk("R7 clear bit1 only", v, 1);
        do_write(5, 0);
        do_read(5, v); chk("R7 zero write keeps", v, 1);
        do_write(5, 31);
        do_read(5, v); chk("R7 clear all", v, 0);

        // R8 interrupt gating
        do_write(6, 2);
        chk("R8 irq idle", int'(irq), 0);
        repeat (4) do_tick();
        chk("R8 irq on sec", int'(irq), 1);
        do_write(6, 0);
        chk("R8 irq masked", int'(irq), 0);
        do_write(5, 31);

        // R3 full rollover
        do_write(2, 23); do_write(1, 59); do_write(0, 59);
        do_write(5, 31);
        repeat (4) do_tick();
        do_read(0, v); chk("R3 sec wrap", v, 0);
        do_read(1, v); chk("R3 min wrap", v, 0);
        do_read(2, v); chk("R3 hr wrap", v, 0);
        do_read(5, v); chk("R3 all events", v, 31);
        do_write(5, 31);

        // R6 out-of-range loads and divider restart
        do_write(0, 70);
        do_read(0, v); chk("R6 sec >59", v, 0);
        do_write(2, 24);
        do_read(2, v); chk("R6 hr >23", v, 0);
        repeat (3) do_tick();
        do_write(0, 10);
        ticks_to_second(n); chk("R6 restart length", n, 4);
        repeat (2) do_tick();
        do_write(0, 20, 1'b1);
        ticks_to_second(n); chk("R6 same-cycle pulse dropped", n, 4);

        // R5 calibration
        do_write(4, 16'h0302);
        do_write(0, 0);
        ticks_to_second(n); chk("R5 window sec1", n, 4);
        ticks_to_second(n); chk("R5 window sec2", n, 4);
        ticks_to_second(n); chk("R5 trimmed sec3", n, 6);
        ticks_to_second(n); chk("R5 next window sec1", n, 4);
        do_write(4, 16'h01FD);
        do_write(0, 0);
        ticks_to_second(n); chk("R5 clamp to 2", n, 2);
        do_write(4, 0);
        do_write(0, 0);
        ticks_to_second(n); chk("R5 disabled", n, 4);
        check_all("R5 model sync");

        // random phase
        for (int i = 0; i < 2500; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 78) do_tick();
            else if (r < 84) do_write(int'($urandom % 3), int'($urandom % 64), 1'($urandom % 2));
            else if (r < 88) do_write(5, int'($urandom % 32));
            else if (r < 91) do_write(6, int'($urandom % 32));
            else if (r < 95) do_write(4, ((int'($urandom % 5)) << 8) | ((int'($urandom % 7) - 3) & 255));
            else if (r < 97) do_write(3, 2 + int'($urandom % 6));
            else begin
                do_write(2, 23); do_write(1, 59); do_write(0, 58);
            end
            check_all("R2 R3 R4 R5 R6 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule